// File: doc/BRIEF.md
# Read-Only Instruction Cache with Single-Cycle Invalidate

This block is a physically addressed, four-way set-associative instruction cache of 128 sets with 32-byte lines. Every line holds a tag and one valid bit, with no dirty or ownership state. Software keeps the cache coherent with memory, because the cache is never snooped. Lines can only be written by a line fill, which brings four 64-bit beats in wrapped order, starting with the beat the requester needed first. A single-cycle invalidate input clears every valid bit at once.

A fetch is a one-cycle request carrying a byte address. One cycle later the cache answers with exactly one of three outcomes. A hit returns the addressed 64-bit double word. A miss tells the requester to start a fill. A wait means the line is being filled but the needed beat has not yet arrived. Fetches keep being served while a fill is in progress. They hit in other resident lines, and they hit in the filling line for beats that have already been written. The choice of way on a fill favours invalid ways, and after that follows a tree pseudo-LRU.

The fill controller has two states. In `S_IDLE` no fill is open. On transition *accept* (a `fill_start` without `flash_inv`) it moves to `S_FILL`. In `S_FILL` it writes one beat for each `fill_beat_valid`. On transition *complete* (the fourth beat) it returns to `S_IDLE`, and on transition *abort* (`flash_inv`) it also returns to `S_IDLE`.

Top module: `icache_flash`

## Requirements
- R1: Address fields are: set index = addr[11:5], tag = addr[31:12], beat index = addr[4:3]. A fetch sampled at a clock edge raises exactly one of `rsp_hit`, `rsp_miss`, `rsp_wait` for the following cycle. A cycle without a fetch leaves all three low.
- R2: After reset every line is invalid, so the first fetch to any address returns a miss.
- R3: A fill accepted with `fill_addr` receives four beats. Beat k of the sequence is written to beat index (fill_addr[4:3] + k) mod 4. After the fourth beat the line is valid, and every double word of it hits with the data that was delivered.
- R4: While a fill is open, a fetch to another resident line hits with its data.
- R5: A fetch to the line being filled hits with data if its beat was written at an earlier edge. Otherwise it returns wait, and that includes a beat arriving in the same cycle as the fetch.
- R6: `flash_inv` makes every line invalid from the next cycle on, so fetches to previously resident lines miss.
- R7: `flash_inv` takes priority over the fill. An open fill is abandoned, its line never becomes valid, and later beats are ignored. A fetch in the same cycle as `flash_inv` misses. A new fill after the invalidate works normally.
- R8: A fill goes to the lowest-numbered invalid way of its set, so four fills to one set leave all four lines resident.
- R9: With the set full, the victim follows a 3-bit tree (root selects half, leaf selects way; touching a way points the tree away from it), updated on hits and fill completion. After lines A, B, C, D are filled and fetched in that order and then A is fetched again, the next fill to that set evicts C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch request this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| rsp_hit | output | 1 | Previous fetch hit; `rsp_data` valid |
| rsp_miss | output | 1 | Previous fetch missed; fill required |
| rsp_wait | output | 1 | Previous fetch targets filling line, beat not yet present |
| rsp_data | output | 64 | Fetched double word |
| fill_start | input | 1 | Open a line fill for `fill_addr` |
| fill_addr | input | 32 | Fill address; bits [4:3] name the first beat |
| fill_beat_valid | input | 1 | One fill beat present this cycle |
| fill_beat_data | input | 64 | Fill beat data |
| flash_inv | input | 1 | Invalidate all lines; abandons any open fill |

## Verification
Two situations are the hardest to set up from the ports. The first is the filling line's own beats being fetched in the middle of a fill. The second is an invalidate that lands partway through a fill. The bench drives fill beats and fetches cycle by cycle from one process. That way a fetch can be placed in the cycle after a beat arrives, in the very cycle a beat arrives, and before a beat comes. It also lets the remaining beats be sent after an invalidate, to show they are dropped. Reaching the replacement tree's choice requires a full set and a known touch order, so the bench fills one set four times, re-touches one line, and then checks which line disappeared.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/icache_victim.sv
module icache_victim #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-1:0]         valid_vec,
    input  logic [WAYS-2:0]         tree,
    output logic [$clog2(WAYS)-1:0] victim
);
    localparam int WAY_W = $clog2(WAYS);

    always_comb begin
        logic             found;
        logic [WAY_W-1:0] walk;
        int               node;
        found = 1'b0;
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!valid_vec[w] && !found) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
        walk = '0;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            walk = {walk[WAY_W-2:0], tree[node]};
            node = 2 * node + 1 + int'(tree[node]);
        end
        if (!found) victim = walk;
    end
endmodule

// File: rtl/icache_plru_upd.sv
module icache_plru_upd #(
    parameter int WAYS = 4
) (
    input  logic [WAYS-2:0]         tree,
    input  logic [$clog2(WAYS)-1:0] way,
    output logic [WAYS-2:0]         tree_nxt
);
    localparam int WAY_W = $clog2(WAYS);

    always_comb begin
        int   node;
        logic b;
        tree_nxt = tree;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            b = way[WAY_W-1-lvl];
            tree_nxt[node] = ~b;
            node = 2 * node + 1 + int'(b);
        end
    end
endmodule

// File: rtl/icache_fill_fsm.sv
module icache_fill_fsm
    import icache_pkg::*;
#(
    parameter int BEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fill_start,
    input  logic                     beat_valid,
    input  logic                     flash_inv,
    input  logic [$clog2(BEATS)-1:0] first_beat,
    output logic                     filling,
    output logic                     start_accept,
    output logic                     beat_we,
    output logic                     fill_done,
    output logic [$clog2(BEATS)-1:0] beat_idx
);
    localparam int BIDX_W = $clog2(BEATS);

    fill_state_e       state_q, state_d;
    logic [BIDX_W-1:0] cnt_q;
    logic [BIDX_W-1:0] first_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= '0;
        end else if (start_accept) begin
            cnt_q   <= '0;
            first_q <= first_beat;
        end else if (beat_we) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        start_accept = 1'b0;
        beat_we      = 1'b0;
        fill_done    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (fill_start && !flash_inv) begin
                    start_accept = 1'b1;
                    state_d      = S_FILL;
                end
            end
            S_FILL: begin
                if (flash_inv) begin
                    state_d = S_IDLE;
                end else if (beat_valid) begin
                    beat_we = 1'b1;
                    if (cnt_q == BIDX_W'(BEATS - 1)) begin
                        fill_done = 1'b1;
                        state_d   = S_IDLE;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign filling  = (state_q == S_FILL);
    assign beat_idx = first_q + cnt_q;

    a_r7_flash_aborts_fill: assert property (@(posedge clk) disable iff (!rst_n)
        flash_inv |=> !filling);
    a_r3_complete_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (state_q == S_IDLE));
    a_r3_beat_counter_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_we && !fill_done) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/icache_flash.sv
module icache_flash #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_W     = 64,
    parameter int ADDR_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_wait,
    output logic [BEAT_W-1:0] rsp_data,
    input  logic              fill_start,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_beat_valid,
    input  logic [BEAT_W-1:0] fill_beat_data,
    input  logic              flash_inv
);
    localparam int BEAT_BYTES = BEAT_W / 8;
    localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
    localparam int BOFF_W     = $clog2(BEAT_BYTES);
    localparam int BIDX_W     = $clog2(BEATS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int SET_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - SET_W - OFF_W;
    localparam int WAY_W      = $clog2(WAYS);
    localparam int ENTRIES    = SETS * WAYS * BEATS;

    // storage
    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic [WAYS-2:0]           tree_q [SETS];
    logic [BEAT_W-1:0]         data_q [ENTRIES];

    // address split
    logic [SET_W-1:0]  f_set, n_set;
    logic [TAG_W-1:0]  f_tag, n_tag;
    logic [BIDX_W-1:0] f_beat, n_first;
    assign f_set   = fetch_addr[OFF_W +: SET_W];
    assign f_tag   = fetch_addr[ADDR_W-1 -: TAG_W];
    assign f_beat  = fetch_addr[BOFF_W +: BIDX_W];
    assign n_set   = fill_addr[OFF_W +: SET_W];
    assign n_tag   = fill_addr[ADDR_W-1 -: TAG_W];
    assign n_first = fill_addr[BOFF_W +: BIDX_W];
    logic unused_low;
    assign unused_low = ^{fetch_addr[BOFF_W-1:0], fill_addr[BOFF_W-1:0]};

    // fill controller
    logic              filling, start_accept, beat_we, fill_done;
    logic [BIDX_W-1:0] beat_idx;
    icache_fill_fsm #(.BEATS(BEATS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .fill_start(fill_start),
        .beat_valid(fill_beat_valid), .flash_inv(flash_inv),
        .first_beat(n_first), .filling(filling), .start_accept(start_accept),
        .beat_we(beat_we), .fill_done(fill_done), .beat_idx(beat_idx)
    );

    // open fill context
    logic [SET_W-1:0] fl_set_q;
    logic [TAG_W-1:0] fl_tag_q;
    logic [WAY_W-1:0] fl_way_q;
    logic [BEATS-1:0] got_q;
    logic [WAY_W-1:0] victim;

    icache_victim #(.WAYS(WAYS)) u_victim (
        .valid_vec(valid_q[n_set]), .tree(tree_q[n_set]), .victim(victim)
    );

    // lookup
    logic [WAYS-1:0]  way_hit;
    logic             any_hit;
    logic [WAY_W-1:0] hit_way, rd_way;
    logic             fill_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_hit[w] = valid_q[f_set][w] && (tag_q[f_set][w] == f_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) hit_way = WAY_W'(w);
        end
    end

    assign any_hit    = |way_hit;
    assign fill_match = filling && (f_set == fl_set_q) && (f_tag == fl_tag_q);
    assign rd_way     = any_hit ? hit_way : fl_way_q;

    // replacement tree updates
    logic [WAYS-2:0] tree_hit_nxt, tree_fill_nxt;
    icache_plru_upd #(.WAYS(WAYS)) u_upd_hit (
        .tree(tree_q[f_set]), .way(hit_way), .tree_nxt(tree_hit_nxt)
    );
    icache_plru_upd #(.WAYS(WAYS)) u_upd_fill (
        .tree(tree_q[fl_set_q]), .way(fl_way_q), .tree_nxt(tree_fill_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
            got_q    <= '0;
            fl_set_q <= '0;
            fl_tag_q <= '0;
            fl_way_q <= '0;
        end else begin
            if (flash_inv) begin
                valid_q <= '0;
            end else begin
                if (start_accept) valid_q[n_set][victim]   <= 1'b0;
                if (fill_done)    valid_q[fl_set_q][fl_way_q] <= 1'b1;
            end
            if (start_accept) begin
                fl_set_q <= n_set;
                fl_tag_q <= n_tag;
                fl_way_q <= victim;
                got_q    <= '0;
            end else if (beat_we) begin
                got_q[beat_idx] <= 1'b1;
            end
            if (fetch_req && any_hit && !flash_inv) tree_q[f_set] <= tree_hit_nxt;
            if (fill_done) tree_q[fl_set_q] <= tree_fill_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (start_accept) tag_q[n_set][victim] <= n_tag;
        if (beat_we) data_q[{fl_set_q, fl_way_q, beat_idx}] <= fill_beat_data;
    end

    // response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit  <= 1'b0;
            rsp_miss <= 1'b0;
            rsp_wait <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_hit  <= 1'b0;
            rsp_miss <= 1'b0;
            rsp_wait <= 1'b0;
            if (fetch_req) begin
                if (flash_inv)                  rsp_miss <= 1'b1;
                else if (any_hit)               rsp_hit  <= 1'b1;
                else if (fill_match && got_q[f_beat]) rsp_hit <= 1'b1;
                else if (fill_match)            rsp_wait <= 1'b1;
                else                            rsp_miss <= 1'b1;
            end
            rsp_data <= data_q[{f_set, rd_way, f_beat}];
        end
    end

    a_r1_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_miss, rsp_wait}));
    a_r1_outcome_tracks_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss || rsp_wait) == $past(fetch_req));
    a_r6_flash_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        flash_inv |=> (valid_q == '0));
    a_r7_flash_fetch_misses: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && flash_inv) |=> rsp_miss);
    a_r5_wait_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wait |-> $past(filling));
endmodule

// File: tb/icache_flash_tb.sv
module icache_flash_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        rsp_hit, rsp_miss, rsp_wait;
    logic [63:0] rsp_data;
    logic        fill_start = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_beat_valid = 1'b0;
    logic [63:0] fill_beat_data = '0;
    logic        flash_inv = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    icache_flash u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_wait(rsp_wait), .rsp_data(rsp_data),
        .fill_start(fill_start), .fill_addr(fill_addr),
        .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
        .flash_inv(flash_inv)
    );

    localparam int K_NONE = 0, K_HIT = 1, K_MISS = 2, K_WAIT = 3;

    function automatic logic [31:0] line_of(int tag, int set);
        return (32'(tag) << 12) | (32'(set) << 5);
    endfunction

    function automatic logic [63:0] bdat(logic [31:0] line, int b);
        return {~line, line | 32'(b)};
    endfunction

    function automatic int kind();
        int n;
        n = int'(rsp_hit) + int'(rsp_miss) + int'(rsp_wait);
        if (n > 1) return 9;
        if (rsp_hit)  return K_HIT;
        if (rsp_miss) return K_MISS;
        if (rsp_wait) return K_WAIT;
        return K_NONE;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // fetch while other inputs hold their current values
    task automatic fetch_chk(logic [31:0] addr, int ek, logic [63:0] ed, string req);
        fetch_req  = 1'b1;
        fetch_addr = addr;
        tick();
        fetch_req = 1'b0;
        chk(kind() == ek, req, "outcome", 64'(kind()), 64'(ek));
        if (ek == K_HIT) chk(rsp_data == ed, req, "data", rsp_data, ed);
    endtask

    task automatic fill_line(logic [31:0] line, int first);
        fill_start = 1'b1;
        fill_addr  = line | (32'(first) << 3);
        tick();
        fill_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            fill_beat_valid = 1'b1;
            fill_beat_data  = bdat(line, (first + i) % 4);
            tick();
        end
        fill_beat_valid = 1'b0;
    endtask

    task automatic check_line(logic [31:0] line, string req);
        for (int b = 0; b < 4; b++) fetch_chk(line | (32'(b) << 3), K_HIT, bdat(line, b), req);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(kind() == K_NONE, "R2", "idle outputs after reset", 64'(kind()), 64'(K_NONE));
        fetch_chk(line_of(1, 3), K_MISS, '0, "R2");
        fetch_chk(line_of(9, 100) | 32'h18, K_MISS, '0, "R2");
    endtask

    task automatic t_fill_order();
        fill_line(line_of(1, 3), 0);
        check_line(line_of(1, 3), "R3");
        fill_line(line_of(2, 3), 2);   // wrapped order 2,3,0,1
        check_line(line_of(2, 3), "R3");
        tick();
        chk(kind() == K_NONE, "R1", "no request no outcome", 64'(kind()), 64'(K_NONE));
    endtask

    task automatic t_fill_set();
        fill_line(line_of(3, 3), 1);
        fill_line(line_of(4, 3), 3);
        for (int t = 1; t <= 4; t++) check_line(line_of(t, 3), "R8");
    endtask

    task automatic t_replace();
        fetch_chk(line_of(1, 3), K_HIT, bdat(line_of(1, 3), 0), "R9");
        fill_line(line_of(5, 3), 0);
        fetch_chk(line_of(3, 3), K_MISS, '0, "R9");
        check_line(line_of(5, 3), "R9");
        fetch_chk(line_of(1, 3), K_HIT, bdat(line_of(1, 3), 0), "R9");
        fetch_chk(line_of(2, 3), K_HIT, bdat(line_of(2, 3), 0), "R9");
        fetch_chk(line_of(4, 3), K_HIT, bdat(line_of(4, 3), 0), "R9");
    endtask

    task automatic t_hit_under_fill();
        logic [31:0] f;
        f = line_of(6, 9);
        fill_start = 1'b1;
        fill_addr  = f | 32'h08;
        tick();
        fill_start = 1'b0;
        fill_beat_valid = 1'b1;
        fill_beat_data  = bdat(f, 1);
        tick();
        fill_beat_valid = 1'b0;
        fetch_chk(f | 32'h08, K_HIT, bdat(f, 1), "R5");
        fill_beat_valid = 1'b1;
        fill_beat_data  = bdat(f, 2);
        fetch_chk(f | 32'h10, K_WAIT, '0, "R5");   // beat arrives same cycle
        fill_beat_valid = 1'b0;
        fetch_chk(line_of(1, 3) | 32'h18, K_HIT, bdat(line_of(1, 3), 3), "R4");
        fetch_chk(f | 32'h10, K_HIT, bdat(f, 2), "R5");
        fetch_chk(f, K_WAIT, '0, "R5");
        fill_beat_valid = 1'b1;
        fill_beat_data  = bdat(f, 3);
        tick();
        fill_beat_data  = bdat(f, 0);
        tick();
        fill_beat_valid = 1'b0;
        check_line(f, "R3");
    endtask

    task automatic t_flash();
        logic [31:0] g;
        g = line_of(7, 20);
        fill_start = 1'b1;
        fill_addr  = g;
        tick();
        fill_start = 1'b0;
        fill_beat_valid = 1'b1;
        fill_beat_data  = bdat(g, 0);
        tick();
        fill_beat_valid = 1'b0;
        flash_inv = 1'b1;
        fetch_chk(line_of(1, 3), K_MISS, '0, "R7");
        flash_inv = 1'b0;
        for (int b = 1; b < 4; b++) begin
            fill_beat_valid = 1'b1;
            fill_beat_data  = bdat(g, b);
            tick();
        end
        fill_beat_valid = 1'b0;
        fetch_chk(g, K_MISS, '0, "R7");
        fetch_chk(g | 32'h18, K_MISS, '0, "R7");
        fetch_chk(line_of(1, 3), K_MISS, '0, "R6");
        fetch_chk(line_of(2, 3), K_MISS, '0, "R6");
        fetch_chk(line_of(4, 3), K_MISS, '0, "R6");
        fetch_chk(line_of(5, 3), K_MISS, '0, "R6");
        fetch_chk(line_of(6, 9), K_MISS, '0, "R6");
        fill_line(g, 2);
        check_line(g, "R7");
    endtask

    initial begin
        t_reset();
        t_fill_order();
        t_fill_set();
        t_replace();
        t_hit_under_fill();
        t_flash();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired, run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule